// File: doc/BRIEF.md
# Master Transfer Data Staging Buffer

This block sits between a memory-mapped register interface and an I2C master transfer engine. It holds up to four data bytes. Software queues bytes here before a transmit. After a receive, the engine deposits the bytes here and software drains them. A read always presents the oldest byte, and when that read completes the remaining bytes move one slot toward the head. When the buffer is empty, a read returns all ones and changes nothing.

Software writes use a valid/ready handshake. `wr_ready` drops while the buffer is full, unless a read completes in the same cycle. A write offered while `wr_ready` is low is not held for later: it is dropped. The read side has no back-pressure. `rd_data` always shows the current head, and a pulse on `rd_req` consumes that byte. The flush strobe, the bulk-load port and the two status flags are plain level pins.

Occupancy is kept as a signed index: -1 means empty and 3 means full. The "some data" flag and the "full" flag follow the index as it crosses 0 and 3.

Top module: `mstr_dbuf`

## Requirements
- R1: While `full` is low and neither `flush` nor `load_en` is high, `wr_ready` is high, and a write with `wr_valid` high is stored behind the bytes already held.
- R2: A read while `not_empty` is low shows `rd_data` = 8'hFF and changes neither the stored bytes nor the flags.
- R3: `rd_data` shows the oldest held byte. A read with `rd_req` high removes it, so that bytes leave in the order they were written or loaded.
- R4: While `full` is high and `rd_req` is low, `wr_ready` is low and a write offered in that cycle is discarded.
- R5: `not_empty` rises on the write that takes the buffer from empty to one byte. It falls on the read that takes it from one byte to empty.
- R6: `full` rises on the write that brings the buffer to four bytes. It falls on a read taken while it holds four bytes, unless that same cycle also writes.
- R7: `flush` empties the buffer, zeroes every slot and clears both flags on the next edge.
- R8: `load_en` replaces all four slots from `load_data`, with slot k taken from bits [8k+7:8k]. It sets the occupancy to `load_count` (0 to 4; larger values are taken as 4), and sets `not_empty` and `full` to match.
- R9: A read and a write in the same cycle act as the read followed by the write. On a non-empty buffer the occupancy is unchanged; on an empty buffer the read returns 8'hFF and the write is stored.
- R10: A synchronous `rst` empties the buffer and clears both flags.
- R11: `flush` takes priority over `load_en`, which takes priority over reads and writes. While either is high, `wr_ready` is low and `rd_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all bytes and zero the slots |
| wr_valid | input | 1 | Software write offered |
| wr_ready | output | 1 | Write will be taken this cycle |
| wr_data | input | 8 | Byte to queue |
| rd_req | input | 1 | Consume the head byte |
| rd_data | output | 8 | Head byte, or 8'hFF when empty |
| load_en | input | 1 | Engine bulk load strobe |
| load_count | input | 3 | Number of valid bytes in the bulk load |
| load_data | input | 32 | Bulk load bytes, slot k in bits [8k+7:8k] |
| not_empty | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |

## Verification
The bench builds the block with its default parameters: four slots of eight bits, so the fill count and the 3-bit load count span every level from empty to full. At this depth, random write/read mixes reach the full boundary often. This exercises the discard of a write that meets a full buffer, a read and a write that coincide on both a full and an empty buffer, and every flag transition. Bulk loads with counts of 0 to 4 (and 5, which clamps) and flushes that collide with loads and writes are mixed in, and a reset is applied in mid-run.

// File: rtl/mstr_dbuf_pkg.sv
package mstr_dbuf_pkg;
  localparam int unsigned DEF_DEPTH = 4;
  localparam int unsigned DEF_WIDTH = 8;

  typedef struct packed {
    logic rd_fire;
    logic wr_fire;
  } dbuf_stb_t;
endpackage

// File: rtl/mstr_dbuf_ctrl.sv
module mstr_dbuf_ctrl
  import mstr_dbuf_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned IDXW  = $clog2(DEPTH) + 1,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            load_en,
  input  logic [CW-1:0]   load_count,
  input  logic            wr_valid,
  input  logic            rd_req,
  output logic            wr_ready,
  output dbuf_stb_t       stb,
  output logic [CW-1:0]   fill,
  output logic            not_empty,
  output logic            full
);
  localparam logic signed [IDXW-1:0] IDX_EMPTY = '1;
  localparam logic signed [IDXW-1:0] IDX_ONE   = IDXW'(1);
  localparam logic signed [IDXW-1:0] IDX_ZERO  = '0;
  localparam logic signed [IDXW-1:0] IDX_LAST  = IDXW'(DEPTH - 1);
  localparam logic signed [IDXW-1:0] IDX_PRE   = IDXW'(DEPTH - 2);
  localparam logic [CW-1:0]          CNT_MAX   = CW'(DEPTH);

  logic signed [IDXW-1:0] idx_q, mid, idx_d;
  logic                   ne_q, full_q, busy, rd_fire, wr_fire;
  logic [CW-1:0]          lc_eff;

  always_comb begin
    busy     = flush | load_en;
    rd_fire  = !busy && rd_req && (idx_q != IDX_EMPTY);
    wr_ready = !busy && (!full_q || rd_req);
    wr_fire  = wr_valid && wr_ready;
    mid      = rd_fire ? idx_q - IDX_ONE : idx_q;
    idx_d    = wr_fire ? mid + IDX_ONE : mid;
    lc_eff   = (load_count > CNT_MAX) ? CNT_MAX : load_count;
    fill     = CW'($unsigned(idx_q + IDX_ONE));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      idx_q  <= IDX_EMPTY;
      ne_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (load_en) begin
      idx_q  <= $signed(IDXW'(lc_eff)) - IDX_ONE;
      ne_q   <= (lc_eff != '0);
      full_q <= (lc_eff == CNT_MAX);
    end else begin
      idx_q <= idx_d;
      if (wr_fire && mid == IDX_EMPTY)
        ne_q <= 1'b1;
      else if (rd_fire && !wr_fire && idx_q == IDX_ZERO)
        ne_q <= 1'b0;
      if (wr_fire && mid == IDX_PRE)
        full_q <= 1'b1;
      else if (rd_fire && !wr_fire && idx_q == IDX_LAST)
        full_q <= 1'b0;
    end
  end

  assign stb.rd_fire = rd_fire;
  assign stb.wr_fire = wr_fire;
  assign not_empty   = ne_q;
  assign full        = full_q;
endmodule

// File: rtl/mstr_dbuf_store.sv
module mstr_dbuf_store
  import mstr_dbuf_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   load_en,
  input  logic [DEPTH*WIDTH-1:0] load_data,
  input  dbuf_stb_t              stb,
  input  logic [CW-1:0]          fill,
  input  logic [WIDTH-1:0]       wr_data,
  output logic [WIDTH-1:0]       head
);
  logic [WIDTH-1:0] ent_q [DEPTH];
  logic [CW-1:0]    wr_slot;

  assign wr_slot = stb.rd_fire ? fill - CW'(1) : fill;
  assign head    = ent_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH - 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst || flush)
          ent_q[i] <= '0;
        else if (load_en)
          ent_q[i] <= load_data[i*WIDTH +: WIDTH];
        else if (stb.wr_fire && wr_slot == CW'(i))
          ent_q[i] <= wr_data;
        else if (stb.rd_fire && CW'(i + 1) < fill)
          ent_q[i] <= ent_q[i+1];
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst || flush)
          ent_q[i] <= '0;
        else if (load_en)
          ent_q[i] <= load_data[i*WIDTH +: WIDTH];
        else if (stb.wr_fire && wr_slot == CW'(i))
          ent_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/mstr_dbuf.sv
module mstr_dbuf
  import mstr_dbuf_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH,
  localparam int unsigned IDXW = $clog2(DEPTH) + 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [WIDTH-1:0]       wr_data,
  input  logic                   rd_req,
  output logic [WIDTH-1:0]       rd_data,
  input  logic                   load_en,
  input  logic [CW-1:0]          load_count,
  input  logic [DEPTH*WIDTH-1:0] load_data,
  output logic                   not_empty,
  output logic                   full
);
  dbuf_stb_t        stb;
  logic [CW-1:0]    fill;
  logic [WIDTH-1:0] head;

  mstr_dbuf_ctrl #(.DEPTH(DEPTH), .IDXW(IDXW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .load_en(load_en),
    .load_count(load_count), .wr_valid(wr_valid), .rd_req(rd_req),
    .wr_ready(wr_ready), .stb(stb), .fill(fill),
    .not_empty(not_empty), .full(full)
  );

  mstr_dbuf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .load_en(load_en),
    .load_data(load_data), .stb(stb), .fill(fill),
    .wr_data(wr_data), .head(head)
  );

  assign rd_data = not_empty ? head : '1;
endmodule

// File: rtl/mstr_dbuf_chk.sv
module mstr_dbuf_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   flush,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [WIDTH-1:0]       wr_data,
  input logic                   rd_req,
  input logic [WIDTH-1:0]       rd_data,
  input logic                   load_en,
  input logic [CW-1:0]          load_count,
  input logic [DEPTH*WIDTH-1:0] load_data,
  input logic                   not_empty,
  input logic                   full
);
  // R2: empty buffer shows all ones
  a_r2_empty_reads_ones: assert property (@(posedge clk) disable iff (rst)
    !not_empty |-> rd_data == '1);

  // R4: no write taken into a full buffer without a read
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_req) |-> !wr_ready);

  // R5: first write sets the some-data flag
  a_r5_first_write_sets: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && wr_valid && wr_ready) |=> not_empty);

  // R6: full implies some data
  a_r6_full_has_data: assert property (@(posedge clk) disable iff (rst)
    full |-> not_empty);

  // R7: flush empties on the next edge
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!not_empty && !full));

  // R11: no write handshake while flush or load is high
  a_r11_busy_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (flush || load_en) |-> !wr_ready);

  // R3: head holds while nothing touches the buffer
  a_r3_head_stable: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !wr_valid && !flush && !load_en) |=> $stable(rd_data));

  // R10: reset leaves the buffer empty
  a_r10_reset_empties: assert property (@(posedge clk)
    rst |=> (!not_empty && !full));
endmodule

bind mstr_dbuf mstr_dbuf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .rd_req(rd_req),
  .rd_data(rd_data), .load_en(load_en), .load_count(load_count),
  .load_data(load_data), .not_empty(not_empty), .full(full)
);

// File: tb/test_mstr_dbuf.sv
module test_mstr_dbuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, load_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  load_count = '0;
  logic [31:0] load_data = '0;
  logic        wr_ready, not_empty, full;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m [4];
  int cnt = 0;
  string ctx = "";

  always #5 clk = ~clk;

  mstr_dbuf i_mstr_dbuf (
    .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .load_en(load_en), .load_count(load_count),
    .load_data(load_data), .not_empty(not_empty), .full(full)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_head();
    return (cnt > 0) ? m[0] : 8'hFF;
  endfunction

  function automatic logic exp_ready(input logic f, input logic l, input logic r);
    return !f && !l && (cnt < 4 || r);
  endfunction

  task automatic check_outputs();
    string hd = (cnt == 0) ? "R2 empty read" : "R3 head order";
    string ft = (ctx != "") ? ctx : "R5 some-data flag";
    string fu = (ctx != "") ? ctx : "R6 full flag";
    string wt = (flush || load_en) ? "R11 busy write" :
                (cnt == 4 && !rd_req) ? "R4 full write" : "R1 write ready";
    chk(rd_data == exp_head(), hd, rd_data, exp_head());
    chk(not_empty == (cnt > 0), ft, not_empty, cnt > 0);
    chk(full == (cnt == 4), fu, full, cnt == 4);
    chk(wr_ready == exp_ready(flush, load_en, rd_req), wt, wr_ready,
        exp_ready(flush, load_en, rd_req));
  endtask

  // apply inputs for one cycle, check, then advance the model across the edge
  task automatic step(input logic f, input logic l, input logic [2:0] lc,
                      input logic [31:0] ld, input logic wv, input logic [7:0] wd,
                      input logic r);
    logic rf, wf;
    int lce;
    @(negedge clk);
    flush = f; load_en = l; load_count = lc; load_data = ld;
    wr_valid = wv; wr_data = wd; rd_req = r;
    #1;
    check_outputs();
    ctx = "";
    if (f) begin
      for (int k = 0; k < 4; k++) m[k] = 8'h00;
      cnt = 0;
      ctx = l ? "R11 flush over load" : "R7 flush";
    end else if (l) begin
      for (int k = 0; k < 4; k++) m[k] = ld[8*k +: 8];
      lce = (lc > 4) ? 4 : int'(lc);
      cnt = lce;
      ctx = "R8 bulk load";
    end else begin
      rf = r && cnt > 0;
      wf = wv && (cnt < 4 || r);
      if (rf) begin
        for (int k = 0; k < 3; k++) m[k] = m[k+1];
        cnt--;
      end
      if (wf) begin
        m[cnt] = wd;
        cnt++;
      end
      if (r && wv) ctx = "R9 read with write";
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; flush = 0; load_en = 0; wr_valid = 0; rd_req = 0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int k = 0; k < 4; k++) m[k] = 8'h00;
    cnt = 0;
    chk(not_empty == 1'b0, "R10 reset some-data", not_empty, 0);
    chk(full == 1'b0, "R10 reset full", full, 0);
    chk(rd_data == 8'hFF, "R10 reset read", rd_data, 8'hFF);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m[k] = 8'h00;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    do_reset();
    // R2: empty read leaves state alone
    step(0, 0, 0, 0, 0, 0, 1);
    idle();
    // R1 / R6: fill to four, R4: extra write dropped
    step(0, 0, 0, 0, 1, 8'hA1, 0);
    step(0, 0, 0, 0, 1, 8'hA2, 0);
    step(0, 0, 0, 0, 1, 8'hA3, 0);
    step(0, 0, 0, 0, 1, 8'hA4, 0);
    step(0, 0, 0, 0, 1, 8'hEE, 0);
    idle();
    // R9: read with write while full
    step(0, 0, 0, 0, 1, 8'hA5, 1);
    idle();
    // R3: drain in order
    repeat (5) step(0, 0, 0, 0, 0, 0, 1);
    // R9: read with write while empty
    step(0, 0, 0, 0, 1, 8'h5C, 1);
    idle();
    // R7: flush, R11: flush with load and write
    step(1, 0, 0, 0, 0, 0, 0);
    idle();
    step(0, 0, 0, 0, 1, 8'h11, 0);
    step(1, 1, 3'd4, 32'hDEADBEEF, 1, 8'h22, 1);
    idle();
    // R8: loads of every count, then drain
    for (int n = 0; n <= 5; n++) begin
      step(0, 1, 3'(n), 32'h4433_2211 + 32'(n), 1, 8'h77, 1);
      repeat (5) step(0, 0, 0, 0, 0, 0, 1);
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int p = $urandom_range(99);
      step(p < 2, (p >= 2 && p < 5) || p == 0, 3'($urandom_range(5)), $urandom,
           $urandom_range(99) < 55, 8'($urandom), $urandom_range(99) < 45);
      if (i == 1500) do_reset();
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule